// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block is the enhanced-mode access path of a printer port controller. A host reaches it through a small register window: a data latch (offset 0), a status view (offset 1), a control register (offset 2), an enhanced-mode address port (offset 3) and an enhanced-mode data port (offset 4). Accesses to the two enhanced-mode ports turn into one or more byte-wide request/acknowledge cycles toward the peripheral. Before any such cycle starts, the block checks the control register.

A mode check requires that the control bits for direction, select-in, init, auto-linefeed and strobe match one exact pattern. One pattern applies to writes and another to reads. An access that fails the check completes at once and produces no peripheral activity. A peripheral that does not acknowledge within a bounded number of clocks aborts the access and sets a sticky timeout flag. Software reads that flag back in status bit 0 and clears it by writing 1 to that bit. Multi-byte data accesses are split into bytes and sent least significant byte first. While a peripheral transfer is in progress, the host is stalled through a ready signal.

Top module: `epp_port_gate`

## Requirements
- R1: After reset the control register reads 0xCC, the data latch reads 0xFF, status bit 0 (timeout) reads 0, the direction output is 0 and no peripheral request is active.
- R2: A control write stores the written byte with bits 7 and 6 forced to 1. The direction output always equals control bit 5.
- R3: A write to the data latch (offset 0) or to control (offset 2) pulses the matching load output for one cycle after the write, and only when the stored value changes. A write that stores the same value again gives no pulse.
- R4: A write to offset 3 or 4 starts peripheral cycles only when control AND 0x2F equals 0x04. Otherwise the write completes in the same cycle and issues no request.
- R5: A read of offset 3 or 4 starts peripheral cycles only when control AND 0x2F equals 0x24. Otherwise it completes in the same cycle and returns all ones in the access width: 0xFF for 1 byte, 0xFFFF for 2 bytes, 0xFFFFFFFF for 4 bytes, with the upper bits zero.
- R6: The size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. Offset 4 moves that many bytes with the address-select output at 0, least significant byte first. Offset 3 always moves one byte with address-select at 1. The write flag output is 1 for host writes and 0 for host reads.
- R7: Each byte waits at most WAIT_LIMIT cycles (default 16) for an acknowledge. An acknowledge in the last of those cycles is still accepted. If no acknowledge arrives, the access ends with no further bytes and sets the timeout flag. Read bytes that were never acknowledged return 0xFF.
- R8: The timeout flag is sticky. A status write with bit 0 set clears it, and a status write with bit 0 clear leaves it unchanged.
- R9: A status read returns the peripheral status input bits 7..1, with bit 0 replaced by the timeout flag.
- R10: Host ready is low from the first request cycle until the transfer finishes or aborts. It then goes high for one cycle with the read data valid. Accesses that start no peripheral cycle are ready in the same cycle.
- R11: An offset 0 read returns the peripheral data input when control bit 5 is 1, and the data latch otherwise. An offset 2 read returns control. Offsets 5 to 7 read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid_i | input | 1 | Host access request, held until ready |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 3 | Register offset |
| host_size_i | input | 2 | Access size code (see R6) |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data, valid when ready |
| host_ready_o | output | 1 | Access completes in this cycle |
| pd_o | output | 8 | Data latch toward the port lines |
| pd_load_o | output | 1 | Data latch changed |
| pd_in_i | input | 8 | Data lines sensed from the port |
| ctl_o | output | 8 | Control register |
| ctl_load_o | output | 1 | Control register changed |
| dir_o | output | 1 | Data direction (1 = input) |
| pst_i | input | 8 | Peripheral status lines |
| pc_req_o | output | 1 | Peripheral byte cycle request |
| pc_asel_o | output | 1 | 1 = address cycle, 0 = data cycle |
| pc_wr_o | output | 1 | 1 = byte write, 0 = byte read |
| pc_wbyte_o | output | 8 | Byte to send |
| pc_ack_i | input | 1 | Peripheral acknowledge |
| pc_rbyte_i | input | 8 | Byte returned on acknowledge |

## Verification
The wait counter reaching its limit and the peripheral acknowledge can land on the same clock. That collision decides whether a byte succeeds or the whole access aborts. The bench's peripheral model acknowledges after a programmable delay. Delays of exactly WAIT_LIMIT and WAIT_LIMIT+1 are run. The bench then judges the outcome from the bytes that were logged and from status bit 0: the first delay must count as success and the second as a timeout that drops the remaining bytes.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_REQ  = 2'd1,
    ENG_GAP  = 2'd2,
    ENG_DONE = 2'd3
  } eng_state_t;

  localparam logic [2:0] OFF_DATA  = 3'd0;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_EADDR = 3'd3;
  localparam logic [2:0] OFF_EDATA = 3'd4;

  localparam logic [7:0] MODE_MASK  = 8'h2F;
  localparam logic [7:0] MODE_WRITE = 8'h04;
  localparam logic [7:0] MODE_READ  = 8'h24;
  localparam logic [7:0] CTRL_RST   = 8'hCC;
  localparam logic [7:0] CTRL_FORCE = 8'hC0;
  localparam logic [7:0] DATA_RST   = 8'hFF;
endpackage

// File: rtl/epp_gate_decode.sv
module epp_gate_decode
  import epp_gate_pkg::*;
#(
  parameter int HOST_W = 32
) (
  input  logic [2:0]          addr_i,
  input  logic [1:0]          size_i,
  input  logic                we_i,
  input  logic [7:0]          ctrl_i,
  output logic                is_epp_o,
  output logic                asel_o,
  output logic                mode_ok_o,
  output logic [$clog2(HOST_W/8)-1:0] last_o,
  output logic [HOST_W-1:0]   wmask_o
);
  localparam int NB = HOST_W / 8;
  localparam int IW = $clog2(NB);

  logic [7:0] masked;

  always_comb begin
    is_epp_o = (addr_i == OFF_EADDR) || (addr_i == OFF_EDATA);
    asel_o   = (addr_i == OFF_EADDR);
    masked   = ctrl_i & MODE_MASK;
    mode_ok_o = we_i ? (masked == MODE_WRITE) : (masked == MODE_READ);
    if (asel_o)            last_o = '0;
    else if (size_i[1])    last_o = IW'(NB - 1);
    else if (size_i[0])    last_o = IW'(1);
    else                   last_o = '0;
  end

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign wmask_o[b*8 +: 8] = (IW'(b) <= last_o) ? 8'hFF : 8'h00;
  end
endmodule

// File: rtl/epp_gate_timer.sv
module epp_gate_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire_o = (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)         cnt_d = '0;
    else if (!expire_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/epp_gate_regs.sv
module epp_gate_regs
  import epp_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wbyte_i,
  input  logic       tmo_set_i,
  input  logic [7:0] pst_i,
  input  logic [7:0] pdin_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] data_o,
  output logic       tmo_o,
  output logic       pd_load_o,
  output logic       ctl_load_o,
  output logic [7:0] rbyte_o
);
  logic [7:0] data_q, data_d, ctrl_q, ctrl_d, ctrl_val;
  logic       tmo_q, tmo_d, pdl_q, pdl_d, ctl_q, ctl_d;

  always_comb begin
    ctrl_val = wbyte_i | CTRL_FORCE;
    data_d = data_q;
    ctrl_d = ctrl_q;
    tmo_d  = tmo_q;
    pdl_d  = 1'b0;
    ctl_d  = 1'b0;
    if (wr_i && addr_i == OFF_DATA && wbyte_i != data_q) begin
      data_d = wbyte_i;
      pdl_d  = 1'b1;
    end
    if (wr_i && addr_i == OFF_CTRL && ctrl_val != ctrl_q) begin
      ctrl_d = ctrl_val;
      ctl_d  = 1'b1;
    end
    if (tmo_set_i)
      tmo_d = 1'b1;
    else if (wr_i && addr_i == OFF_STAT && wbyte_i[0])
      tmo_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DATA_RST;
      ctrl_q <= CTRL_RST;
      tmo_q  <= 1'b0;
      pdl_q  <= 1'b0;
      ctl_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      ctrl_q <= ctrl_d;
      tmo_q  <= tmo_d;
      pdl_q  <= pdl_d;
      ctl_q  <= ctl_d;
    end
  end

  always_comb begin
    case (addr_i)
      OFF_DATA: rbyte_o = ctrl_q[5] ? pdin_i : data_q;
      OFF_STAT: rbyte_o = (pst_i & 8'hFE) | {7'b0, tmo_q};
      OFF_CTRL: rbyte_o = ctrl_q;
      default:  rbyte_o = 8'hFF;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign data_o     = data_q;
  assign tmo_o      = tmo_q;
  assign pd_load_o  = pdl_q;
  assign ctl_load_o = ctl_q;
endmodule

// File: rtl/epp_gate_engine.sv
module epp_gate_engine
  import epp_gate_pkg::*;
#(
  parameter int HOST_W     = 32,
  parameter int WAIT_LIMIT = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                asel_i,
  input  logic                wr_i,
  input  logic [$clog2(HOST_W/8)-1:0] last_i,
  input  logic [HOST_W-1:0]   wdata_i,
  input  logic [HOST_W-1:0]   wmask_i,
  input  logic                ack_i,
  input  logic [7:0]          rbyte_i,
  output eng_state_t          state_o,
  output logic                req_o,
  output logic                asel_o,
  output logic                wr_o,
  output logic [7:0]          wbyte_o,
  output logic                abort_o,
  output logic [HOST_W-1:0]   acc_o
);
  localparam int NB = HOST_W / 8;
  localparam int IW = $clog2(NB);

  eng_state_t        state_q, state_d;
  logic [IW-1:0]     idx_q, idx_d, last_q, last_d;
  logic              asel_q, asel_d, wr_q, wr_d;
  logic [HOST_W-1:0] wbuf_q, wbuf_d, acc_q, acc_d;
  logic              expire;

  epp_gate_timer #(.LIMIT(WAIT_LIMIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (state_q == ENG_REQ),
    .expire_o (expire)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    last_d  = last_q;
    asel_d  = asel_q;
    wr_d    = wr_q;
    wbuf_d  = wbuf_q;
    acc_d   = acc_q;
    abort_o = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (start_i) begin
          state_d = ENG_REQ;
          idx_d   = '0;
          last_d  = last_i;
          asel_d  = asel_i;
          wr_d    = wr_i;
          wbuf_d  = wdata_i;
          acc_d   = wmask_i;
        end
      end
      ENG_REQ: begin
        if (ack_i) begin
          if (!wr_q) acc_d[{idx_q, 3'b000} +: 8] = rbyte_i;
          if (idx_q == last_q) begin
            state_d = ENG_DONE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ENG_GAP;
          end
        end else if (expire) begin
          abort_o = 1'b1;
          state_d = ENG_DONE;
        end
      end
      ENG_GAP:  state_d = ENG_REQ;
      default:  state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      asel_q  <= 1'b0;
      wr_q    <= 1'b0;
      wbuf_q  <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      asel_q  <= asel_d;
      wr_q    <= wr_d;
      wbuf_q  <= wbuf_d;
      acc_q   <= acc_d;
    end
  end

  assign state_o = state_q;
  assign req_o   = (state_q == ENG_REQ);
  assign asel_o  = asel_q;
  assign wr_o    = wr_q;
  assign wbyte_o = wbuf_q[{idx_q, 3'b000} +: 8];
  assign acc_o   = acc_q;
endmodule

// File: rtl/epp_port_gate.sv
module epp_port_gate
  import epp_gate_pkg::*;
#(
  parameter int HOST_W     = 32,
  parameter int WAIT_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid_i,
  input  logic              host_we_i,
  input  logic [2:0]        host_addr_i,
  input  logic [1:0]        host_size_i,
  input  logic [HOST_W-1:0] host_wdata_i,
  output logic [HOST_W-1:0] host_rdata_o,
  output logic              host_ready_o,
  output logic [7:0]        pd_o,
  output logic              pd_load_o,
  input  logic [7:0]        pd_in_i,
  output logic [7:0]        ctl_o,
  output logic              ctl_load_o,
  output logic              dir_o,
  input  logic [7:0]        pst_i,
  output logic              pc_req_o,
  output logic              pc_asel_o,
  output logic              pc_wr_o,
  output logic [7:0]        pc_wbyte_o,
  input  logic              pc_ack_i,
  input  logic [7:0]        pc_rbyte_i
);
  localparam int IW = $clog2(HOST_W / 8);

  eng_state_t        eng_state;
  logic              is_epp, asel, mode_ok, start, reg_wr, abort, tmo_q;
  logic [IW-1:0]     last_idx;
  logic [HOST_W-1:0] wmask, acc;
  logic [7:0]        ctrl, rbyte;

  epp_gate_decode #(.HOST_W(HOST_W)) u_dec (
    .addr_i    (host_addr_i),
    .size_i    (host_size_i),
    .we_i      (host_we_i),
    .ctrl_i    (ctrl),
    .is_epp_o  (is_epp),
    .asel_o    (asel),
    .mode_ok_o (mode_ok),
    .last_o    (last_idx),
    .wmask_o   (wmask)
  );

  assign start  = host_valid_i && (eng_state == ENG_IDLE) && is_epp && mode_ok;
  assign reg_wr = host_valid_i && host_we_i && (eng_state == ENG_IDLE) && !is_epp;

  epp_gate_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .addr_i     (host_addr_i),
    .wbyte_i    (host_wdata_i[7:0]),
    .tmo_set_i  (abort),
    .pst_i      (pst_i),
    .pdin_i     (pd_in_i),
    .ctrl_o     (ctrl),
    .data_o     (pd_o),
    .tmo_o      (tmo_q),
    .pd_load_o  (pd_load_o),
    .ctl_load_o (ctl_load_o),
    .rbyte_o    (rbyte)
  );

  epp_gate_engine #(.HOST_W(HOST_W), .WAIT_LIMIT(WAIT_LIMIT)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .asel_i  (asel),
    .wr_i    (host_we_i),
    .last_i  (last_idx),
    .wdata_i (host_wdata_i),
    .wmask_i (wmask),
    .ack_i   (pc_ack_i),
    .rbyte_i (pc_rbyte_i),
    .state_o (eng_state),
    .req_o   (pc_req_o),
    .asel_o  (pc_asel_o),
    .wr_o    (pc_wr_o),
    .wbyte_o (pc_wbyte_o),
    .abort_o (abort),
    .acc_o   (acc)
  );

  always_comb begin
    if (eng_state == ENG_DONE)      host_rdata_o = acc;
    else if (is_epp)                host_rdata_o = wmask;
    else                            host_rdata_o = {{(HOST_W-8){1'b0}}, rbyte};
    if (eng_state == ENG_IDLE)      host_ready_o = !start;
    else                            host_ready_o = (eng_state == ENG_DONE);
  end

  assign ctl_o = ctrl;
  assign dir_o = ctrl[5];
endmodule

// File: rtl/epp_port_gate_chk.sv
module epp_port_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl,
  input logic       ctl_load,
  input logic       pc_req,
  input logic       pc_wr,
  input logic       ready,
  input logic       tmo,
  input logic       wr_commit,
  input logic [2:0] addr,
  input logic       wbit0
);
  // R4
  wr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pc_req) && pc_wr) |-> ((ctl & 8'h2F) == 8'h04));
  // R5
  rd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pc_req) && !pc_wr) |-> ((ctl & 8'h2F) == 8'h24));
  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_req |-> !ready);
  // R3
  ctl_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |-> (ctl != $past(ctl)));
  // R2
  ctl_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[7:6] == 2'b11);
  // R8
  tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo) |-> $past(wr_commit && addr == 3'd1 && wbit0));
  // R7
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !(wr_commit && addr == 3'd1 && wbit0)) |=> tmo);
endmodule

bind epp_port_gate epp_port_gate_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl       (ctl_o),
  .ctl_load  (ctl_load_o),
  .pc_req    (pc_req_o),
  .pc_wr     (pc_wr_o),
  .ready     (host_ready_o),
  .tmo       (tmo_q),
  .wr_commit (reg_wr),
  .addr      (host_addr_i),
  .wbit0     (host_wdata_i[0])
);

// File: tb/epp_port_gate_tb_top.sv
module epp_port_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid_i = 1'b0, host_we_i = 1'b0;
  logic [2:0]  host_addr_i = '0;
  logic [1:0]  host_size_i = '0;
  logic [31:0] host_wdata_i = '0, host_rdata_o;
  logic        host_ready_o;
  logic [7:0]  pd_o, ctl_o, pc_wbyte_o;
  logic        pd_load_o, ctl_load_o, dir_o, pc_req_o, pc_asel_o, pc_wr_o;
  logic [7:0]  pd_in_i = 8'h3C, pst_i = 8'hB7, pc_rbyte_i = 8'h00;
  logic        pc_ack_i = 1'b0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  epp_port_gate dut_i (.*);

  // peripheral model
  int ack_delay = 2, ack_budget = 100, wcnt = 0, acked = 0, nlog = 0, req_rises = 0;
  logic [7:0] log_byte [0:63];
  logic       log_asel [0:63];
  logic       prev_req = 1'b0;

  always @(negedge clk) begin
    if (pc_req_o && acked < ack_budget) begin
      wcnt = wcnt + 1;
      if (wcnt == ack_delay) begin
        pc_ack_i   = 1'b1;
        pc_rbyte_i = 8'hA0 + 8'(acked);
        log_byte[nlog & 63] = pc_wbyte_o;
        log_asel[nlog & 63] = pc_asel_o;
        nlog  = nlog + 1;
        acked = acked + 1;
      end else pc_ack_i = 1'b0;
    end else begin
      wcnt = 0;
      pc_ack_i = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (pc_req_o && !prev_req) req_rises <= req_rises + 1;
    prev_req <= pc_req_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [2:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(posedge clk); #1;
    acked = 0;
    host_valid_i = 1'b1; host_we_i = we; host_addr_i = a;
    host_size_i = sz; host_wdata_i = wd;
    cyc = 0;
    rd = '0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      cyc++;
      if (host_ready_o) begin
        rd = host_rdata_o;
        break;
      end
    end
    @(posedge clk); #1;
    host_valid_i = 1'b0;
  endtask

  typedef struct packed {
    logic        chk;
    logic        we;
    logic [2:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd2, 2'd0, 32'h0, 32'h0000_00CC, 8'd1},  // R1 control reset
    '{1'b1, 1'b0, 3'd0, 2'd0, 32'h0, 32'h0000_00FF, 8'd1},  // R1 data reset
    '{1'b1, 1'b0, 3'd1, 2'd0, 32'h0, 32'h0000_00B6, 8'd9},  // R9 status view
    '{1'b0, 1'b1, 3'd2, 2'd0, 32'h20, 32'h0, 8'd2},
    '{1'b1, 1'b0, 3'd2, 2'd0, 32'h0, 32'h0000_00E0, 8'd2},  // R2 forced bits
    '{1'b1, 1'b0, 3'd0, 2'd0, 32'h0, 32'h0000_003C, 8'd11}, // R11 input lines
    '{1'b1, 1'b0, 3'd6, 2'd0, 32'h0, 32'h0000_00FF, 8'd11}, // R11 unused offset
    '{1'b1, 1'b0, 3'd4, 2'd1, 32'h0, 32'h0000_FFFF, 8'd5},  // R5 bad mode 16-bit
    '{1'b1, 1'b0, 3'd3, 2'd0, 32'h0, 32'h0000_00FF, 8'd5},  // R5 bad mode addr
    '{1'b0, 1'b1, 3'd4, 2'd0, 32'h11, 32'h0, 8'd4},         // R4 dropped write
    '{1'b0, 1'b1, 3'd2, 2'd0, 32'h04, 32'h0, 8'd2},
    '{1'b1, 1'b0, 3'd4, 2'd2, 32'h0, 32'hFFFF_FFFF, 8'd5},  // R5 write mode blocks read
    '{1'b0, 1'b1, 3'd0, 2'd0, 32'h55, 32'h0, 8'd3},
    '{1'b1, 1'b0, 3'd2, 2'd0, 32'h0, 32'h0000_00C4, 8'd2},
    '{1'b1, 1'b0, 3'd0, 2'd0, 32'h0, 32'h0000_0055, 8'd11}  // R11 latch view
  };

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc, base;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset outputs
    check("R1 dir", {31'b0, dir_o}, 32'd0);
    check("R1 req", {31'b0, pc_req_o}, 32'd0);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      acc(VECS[i].we, VECS[i].addr, VECS[i].size, VECS[i].wdata, rd, cyc);
      if (VECS[i].chk) check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
      check("R10 same-cycle", cyc, 1);
    end
    check("R4 no request", req_rises, 0);

    // R3 unchanged writes give no pulse, changes do
    acc(1'b1, 3'd0, 2'd0, 32'h55, rd, cyc);
    check("R3 same data", {31'b0, pd_load_o}, 0);
    acc(1'b1, 3'd0, 2'd0, 32'h66, rd, cyc);
    check("R3 new data", {31'b0, pd_load_o}, 1);
    check("R3 data value", {24'b0, pd_o}, 32'h66);
    acc(1'b1, 3'd2, 2'd0, 32'h04, rd, cyc);
    check("R3 same ctrl", {31'b0, ctl_load_o}, 0);

    // R6 four-byte write, LSB first
    base = nlog;
    ack_delay = 2;
    acc(1'b1, 3'd4, 2'd2, 32'h4433_2211, rd, cyc);
    check("R6 count", nlog - base, 4);
    check("R6 b0", {24'b0, log_byte[base]}, 32'h11);
    check("R6 b3", {24'b0, log_byte[base+3]}, 32'h44);
    check("R6 asel data", {31'b0, log_asel[base]}, 0);
    check("R10 stalled", {31'b0, (cyc > 1)}, 1);
    base = nlog;
    acc(1'b1, 3'd3, 2'd2, 32'h0000_009A, rd, cyc);
    check("R6 addr one byte", nlog - base, 1);
    check("R6 addr sel", {31'b0, log_asel[base]}, 1);

    // R7 boundary: ack in last wait cycle accepted
    base = nlog;
    ack_delay = 16;
    acc(1'b1, 3'd4, 2'd0, 32'h77, rd, cyc);
    check("R7 last-cycle ack", nlog - base, 1);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd, cyc);
    check("R7 no timeout", rd & 32'h1, 0);
    // one cycle later: abort, remaining bytes skipped
    base = nlog;
    ack_delay = 17;
    acc(1'b1, 3'd4, 2'd2, 32'h1234_5678, rd, cyc);
    check("R7 abort bytes", nlog - base, 0);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd, cyc);
    check("R7 timeout set", rd, 32'h0000_00B7);

    // R8 sticky flag
    acc(1'b1, 3'd1, 2'd0, 32'h0, rd, cyc);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd, cyc);
    check("R8 kept", rd & 32'h1, 1);
    acc(1'b1, 3'd1, 2'd0, 32'h1, rd, cyc);
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd, cyc);
    check("R8 cleared", rd & 32'h1, 0);

    // R5 read mode, R2 direction
    ack_delay = 2;
    acc(1'b1, 3'd2, 2'd0, 32'h24, rd, cyc);
    check("R2 dir", {31'b0, dir_o}, 1);
    acc(1'b0, 3'd4, 2'd2, 32'h0, rd, cyc);
    check("R5 read word", rd, 32'hA3A2_A1A0);
    acc(1'b0, 3'd4, 2'd1, 32'h0, rd, cyc);
    check("R6 read half", rd, 32'h0000_A1A0);
    // R7 partial read fill
    ack_budget = 2;
    acc(1'b0, 3'd4, 2'd2, 32'h0, rd, cyc);
    check("R7 partial read", rd, 32'hFFFF_A1A0);
    ack_budget = 100;
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd, cyc);
    check("R7 read timeout", rd & 32'h1, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule